// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block is the control side of a display writeback path that stores one full frame of pixels into memory in raster order. Software programs a destination base, a byte pitch and the frame size through a small 32-bit register window. It then sets the start bit. From that point the block walks the frame line by line, and within each line beat by beat. For every beat it presents a write address to a downstream bus master over a plain request/acknowledge port. Pixel data and packing travel on a separate path and are not handled here.

The block counts a line as committed only when the last beat of that line is acknowledged. That count is visible to software. When the final line is committed, or when software aborts the frame, the block returns to idle. If enabled, it raises an interrupt at that point. Illegal geometry or alignment is refused at start time and reported through an error flag. A frame is never begun with such settings.

Top module: `wbk_frame_ctrl`

## Requirements
- R1: After reset, the register at offset 0x0C reads 0x5440_0000: bits 31:24 are the fixed tag 0x54 and bits 23:22 are the fixed value 01. Offsets 0x00 (base), 0x04 (pitch), 0x08 (size: height in 31:16, width in 15:0) and 0x10 (committed lines) read 0, and `mem_req` is low.
- R2: A write to 0x0C with bit 0 set, while idle and with a legal setup, starts a frame. From the next clock, bit 1 of 0x0C reads 1 and `mem_req` is high. Bit 0 always reads 0.
- R3: Beat k of line n is requested at address base + n*pitch + 16*k. Each line holds ceil(width/4) beats. `mem_req` and `mem_addr` hold steady until `mem_ack` is sampled high.
- R4: Register 0x10 is cleared by an accepted start. It rises by one on the clock where the last beat of a line is acknowledged, and never counts a partial line.
- R5: On the clock where the final beat of the final line is acknowledged, bit 1 falls. If bit 2 (interrupt enable) is set, `irq` rises on that same clock. Any write to 0x0C with bit 2 clear drops `irq`.
- R6: A start request written while a frame is running is ignored. The line count and the address sequence carry on unchanged.
- R7: A write to 0x0C with bit 14 set while running ends the frame on that clock. From the next clock `mem_req` and bit 1 are low, the line count holds, and `irq` rises if bit 2 was written as 1.
- R8: A start is refused, and bit 15 of 0x0C is set, if any of these holds: width is 0 or above 1920; height is 0 or above 4088; pitch bits 3:0 are not zero; base bits 1:0 are not zero. Bit 15 clears on the next accepted start. The limits 1920 and 4088 themselves are accepted.
- R9: Bit 21 of 0x0C (line memory power-down) is stored and read back. A start written together with bit 21 set is ignored and does not set bit 15.
- R10: Writes to 0x00, 0x04 or 0x08 during a frame do not alter the addresses or line count of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on `bus_addr` |
| mem_req | output | 1 | Write beat request to the bus master |
| mem_addr | output | 32 | Byte address of the requested beat |
| mem_ack | input | 1 | Beat accepted by the bus master |
| irq | output | 1 | Frame-idle interrupt |

## Verification
The hardest situations to reach are the ones that need a register write to land while a frame is part-way through. Examples are an abort between two beats of a line, or a start plus new geometry arriving after one line is committed. The stimulus gets there by answering beats one at a time, with chosen acknowledge delays. It stops after a known beat count and issues the write while a request is still waiting. The following addresses and the line count then show whether the running frame was disturbed. The 1920-wide and 4088-high limits are started for real and then aborted, which keeps the run short.

// File: rtl/wbk_pkg.sv
package wbk_pkg;

    localparam int WORD_W = 32;
    localparam int DIM_W  = 16;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_PTR   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
    localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_PROG  = 5'h10;

    localparam int CB_GO    = 0;
    localparam int CB_BUSY  = 1;
    localparam int CB_IEN   = 2;
    localparam int CB_ABORT = 14;
    localparam int CB_ERR   = 15;
    localparam int CB_PWD   = 21;

    localparam logic [7:0] ID_TAG = 8'h54;
    localparam logic [1:0] ID_REV = 2'b01;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] pitch;
        logic [DIM_W-1:0]  height;
        logic [DIM_W-1:0]  width;
    } frame_cfg_t;

    function automatic logic cfg_ok(input frame_cfg_t c,
                                    input logic [DIM_W-1:0] max_w,
                                    input logic [DIM_W-1:0] max_h);
        return (c.width != '0) && (c.width <= max_w) &&
               (c.height != '0) && (c.height <= max_h) &&
               (c.pitch[3:0] == 4'h0) && (c.ptr[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/wbk_regs.sv
module wbk_regs
    import wbk_pkg::*;
#(
    parameter int MAX_WIDTH  = 1920,
    parameter int MAX_HEIGHT = 4088
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic [DIM_W-1:0]  progress,
    output frame_cfg_t        cfg,
    output logic              start_req,
    output logic              abort_req,
    output logic              irq
);

    localparam logic [DIM_W-1:0] LIM_W = DIM_W'(MAX_WIDTH);
    localparam logic [DIM_W-1:0] LIM_H = DIM_W'(MAX_HEIGHT);

    logic ien_q, pwd_q, err_q, pend_q;
    logic ctrl_wr, go_wr, go_live, cfg_good, irq_clr;

    assign ctrl_wr   = bus_we && (bus_addr == OFS_CTRL);
    assign go_wr     = ctrl_wr && bus_wdata[CB_GO];
    assign go_live   = go_wr && !busy && !bus_wdata[CB_PWD];
    assign cfg_good  = cfg_ok(cfg, LIM_W, LIM_H);
    assign start_req = go_live && cfg_good;
    assign abort_req = ctrl_wr && bus_wdata[CB_ABORT] && busy;
    assign irq_clr   = start_req || (ctrl_wr && !bus_wdata[CB_IEN]);
    assign irq       = pend_q && ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            ien_q  <= 1'b0;
            pwd_q  <= 1'b0;
            err_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (bus_we) begin
                case (bus_addr)
                    OFS_PTR:   cfg.ptr   <= bus_wdata;
                    OFS_PITCH: cfg.pitch <= bus_wdata;
                    OFS_DIM: begin
                        cfg.height <= bus_wdata[31:16];
                        cfg.width  <= bus_wdata[15:0];
                    end
                    default: ;
                endcase
            end
            if (ctrl_wr) begin
                ien_q <= bus_wdata[CB_IEN];
                pwd_q <= bus_wdata[CB_PWD];
            end
            if (go_live) err_q <= !cfg_good;
            if (irq_clr)  pend_q <= 1'b0;
            else if (fin) pend_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PTR:   bus_rdata = cfg.ptr;
            OFS_PITCH: bus_rdata = cfg.pitch;
            OFS_DIM:   bus_rdata = {cfg.height, cfg.width};
            OFS_CTRL: begin
                bus_rdata[31:24]  = ID_TAG;
                bus_rdata[23:22]  = ID_REV;
                bus_rdata[CB_PWD] = pwd_q;
                bus_rdata[CB_ERR] = err_q;
                bus_rdata[CB_IEN] = ien_q;
                bus_rdata[CB_BUSY] = busy;
            end
            OFS_PROG:  bus_rdata = {{(WORD_W-DIM_W){1'b0}}, progress};
            default:   bus_rdata = '0;
        endcase
    end

    // R8
    bad_cfg_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (go_live && !cfg_good) |=> !busy);

    // R9
    pwd_blocks_go_chk: assert property (@(posedge clk) disable iff (rst)
        (go_wr && bus_wdata[CB_PWD] && !busy) |=> !busy);

    // R5
    irq_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);

    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[CB_IEN]) |=> !irq);

endmodule

// File: rtl/wbk_seq.sv
module wbk_seq
    import wbk_pkg::*;
#(
    parameter int MAX_WIDTH    = 1920,
    parameter int PIX_PER_BEAT = 4,
    parameter int BEAT_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_cfg_t        cfg,
    input  logic              start_req,
    input  logic              abort_req,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              busy,
    output logic              fin,
    output logic [DIM_W-1:0]  progress
);

    localparam int MAX_BEATS = (MAX_WIDTH + PIX_PER_BEAT - 1) / PIX_PER_BEAT;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
    localparam logic [WORD_W-1:0] BEAT_STEP = WORD_W'(BEAT_BYTES);

    run_state_e        state;
    logic [DIM_W-1:0]  height_q;
    logic [BEAT_W-1:0] beats_q, beat_cnt, beats_new;
    logic [WORD_W-1:0] pitch_q, line_base, beat_addr;
    logic              last_beat, last_line, run;

    assign beats_new = BEAT_W'((32'(cfg.width) + PIX_PER_BEAT - 1) / PIX_PER_BEAT);
    assign run       = (state == ST_RUN);
    assign last_beat = (beat_cnt == beats_q - 1'b1);
    assign last_line = (progress == height_q - 1'b1);
    assign fin       = run && (abort_req || (mem_ack && last_beat && last_line));
    assign mem_req   = run;
    assign busy      = run;
    assign mem_addr  = beat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            height_q  <= '0;
            beats_q   <= '0;
            beat_cnt  <= '0;
            pitch_q   <= '0;
            line_base <= '0;
            beat_addr <= '0;
            progress  <= '0;
        end else if (!run) begin
            if (start_req) begin
                state     <= ST_RUN;
                height_q  <= cfg.height;
                beats_q   <= beats_new;
                pitch_q   <= cfg.pitch;
                line_base <= cfg.ptr;
                beat_addr <= cfg.ptr;
                beat_cnt  <= '0;
                progress  <= '0;
            end
        end else if (abort_req) begin
            state <= ST_IDLE;
        end else if (mem_ack) begin
            if (last_beat) begin
                progress  <= progress + 1'b1;
                beat_cnt  <= '0;
                line_base <= line_base + pitch_q;
                beat_addr <= line_base + pitch_q;
                if (last_line) state <= ST_IDLE;
            end else begin
                beat_cnt  <= beat_cnt + 1'b1;
                beat_addr <= beat_addr + BEAT_STEP;
            end
        end
    end

    // R3
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !abort_req) |=> (mem_req && $stable(mem_addr)));

    // R7
    abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_req && mem_req) |=> (!mem_req && !busy && $stable(progress)));

    // R4
    prog_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (progress < height_q));

    // R4
    prog_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((progress == $past(progress)) || (progress == $past(progress) + 1'b1)));

endmodule

// File: rtl/wbk_frame_ctrl.sv
module wbk_frame_ctrl
    import wbk_pkg::*;
#(
    parameter int MAX_WIDTH    = 1920,
    parameter int MAX_HEIGHT   = 4088,
    parameter int PIX_PER_BEAT = 4,
    parameter int BEAT_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              irq
);

    frame_cfg_t       cfg;
    logic             start_req, abort_req, busy, fin;
    logic [DIM_W-1:0] progress;

    wbk_regs #(
        .MAX_WIDTH (MAX_WIDTH),
        .MAX_HEIGHT(MAX_HEIGHT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .fin      (fin),
        .progress (progress),
        .cfg      (cfg),
        .start_req(start_req),
        .abort_req(abort_req),
        .irq      (irq)
    );

    wbk_seq #(
        .MAX_WIDTH   (MAX_WIDTH),
        .PIX_PER_BEAT(PIX_PER_BEAT),
        .BEAT_BYTES  (BEAT_BYTES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .start_req(start_req),
        .abort_req(abort_req),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .busy     (busy),
        .fin      (fin),
        .progress (progress)
    );

endmodule

// File: tb/wbk_frame_ctrl_bench.sv
`timescale 1ns/1ps
module wbk_frame_ctrl_bench;

    localparam logic [31:0] IDLE_CTRL = 32'h5440_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    wbk_frame_ctrl u_wbk_frame_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic setup(input logic [31:0] p, input logic [31:0] pit,
                         input logic [15:0] h, input logic [15:0] w);
        wr(5'h00, p); wr(5'h04, pit); wr(5'h08, {h, w});
    endtask

    task automatic serve(input string tag, input logic [31:0] exp_addr, input int dly);
        int guard = 0;
        while (!mem_req && guard < 100) begin
            @(negedge clk); guard++;
        end
        chk({tag, " req"}, {31'b0, mem_req}, 32'h1);
        chk({tag, " addr"}, mem_addr, exp_addr);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk({tag, " hold"}, mem_addr, exp_addr);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h0C, d); chk("R1 ctrl", d, IDLE_CTRL);
        rd(5'h00, d); chk("R1 ptr", d, 32'h0);
        rd(5'h04, d); chk("R1 pitch", d, 32'h0);
        rd(5'h08, d); chk("R1 dim", d, 32'h0);
        rd(5'h10, d); chk("R1 prog", d, 32'h0);
        chk("R1 req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        setup(32'h1000, 32'd64, 16'd3, 16'd8);
        wr(5'h0C, 32'h5);
        rd(5'h0C, d); chk("R2 busy", d, IDLE_CTRL | 32'h6);
        for (int n = 0; n < 3; n++) begin
            for (int k = 0; k < 2; k++)
                serve("R3 basic", 32'h1000 + 32'(n * 64 + k * 16), (n + k) % 3);
            rd(5'h10, d); chk("R4 prog", d, 32'(n + 1));
        end
        rd(5'h0C, d); chk("R5 idle", d, IDLE_CTRL | 32'h4);
        chk("R5 irq up", {31'b0, irq}, 32'h1);
        wr(5'h0C, 32'h0);
        chk("R5 irq clr", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ceil;
        logic [31:0] d;
        setup(32'h2004, 32'h20, 16'd2, 16'd5);
        wr(5'h0C, 32'h1);
        serve("R3 ceil", 32'h2004, 0);
        serve("R3 ceil", 32'h2014, 1);
        rd(5'h10, d); chk("R4 ceil prog", d, 32'h1);
        serve("R3 ceil", 32'h2024, 0);
        serve("R3 ceil", 32'h2034, 0);
        rd(5'h0C, d); chk("R5 ceil idle", d, IDLE_CTRL);
        chk("R5 no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_go_busy;
        logic [31:0] d;
        setup(32'h3000, 32'h10, 16'd2, 16'd4);
        wr(5'h0C, 32'h1);
        serve("R6 first", 32'h3000, 0);
        wr(5'h00, 32'h9000); wr(5'h04, 32'h100); wr(5'h08, {16'd9, 16'd64});
        wr(5'h0C, 32'h1);
        rd(5'h10, d); chk("R6 prog kept", d, 32'h1);
        serve("R10 addr", 32'h3010, 0);
        rd(5'h10, d); chk("R10 prog", d, 32'h2);
        rd(5'h0C, d); chk("R6 idle", d, IDLE_CTRL);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        setup(32'h4000, 32'd32, 16'd4, 16'd8);
        wr(5'h0C, 32'h5);
        serve("R7 pre", 32'h4000, 0);
        serve("R7 pre", 32'h4010, 0);
        serve("R7 pre", 32'h4020, 0);
        wr(5'h0C, 32'h4004);
        chk("R7 req low", {31'b0, mem_req}, 32'h0);
        rd(5'h0C, d); chk("R7 idle", d, IDLE_CTRL | 32'h4);
        rd(5'h10, d); chk("R7 prog held", d, 32'h1);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        wr(5'h0C, 32'h0);
        chk("R7 irq clr", {31'b0, irq}, 32'h0);
    endtask

    task automatic bad_go(input string tag);
        logic [31:0] d;
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk(tag, d, IDLE_CTRL | 32'h8000);
        chk({tag, " req"}, {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_limits;
        logic [31:0] d;
        setup(32'h5000, 32'h10, 16'd4089, 16'd4);   bad_go("R8 height");
        setup(32'h5000, 32'h10, 16'd4, 16'd1921);   bad_go("R8 width");
        setup(32'h5000, 32'h10, 16'd0, 16'd4);      bad_go("R8 zero h");
        setup(32'h5000, 32'h18, 16'd4, 16'd4);      bad_go("R8 pitch");
        setup(32'h5002, 32'h10, 16'd4, 16'd4);      bad_go("R8 ptr");
        setup(32'h5000, 32'h1E00, 16'd1, 16'd1920);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R8 maxw start err clr", d, IDLE_CTRL | 32'h2);
        serve("R8 maxw", 32'h5000, 0);
        serve("R8 maxw", 32'h5010, 0);
        wr(5'h0C, 32'h4000);
        setup(32'h6000, 32'h10, 16'd4088, 16'd4);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R8 maxh start", d, IDLE_CTRL | 32'h2);
        serve("R8 maxh", 32'h6000, 0);
        serve("R8 maxh", 32'h6010, 0);
        wr(5'h0C, 32'h4000);
        rd(5'h10, d); chk("R8 maxh prog", d, 32'h2);
    endtask

    task automatic t_pwd;
        logic [31:0] d;
        setup(32'h7000, 32'h10, 16'd1, 16'd4);
        wr(5'h0C, 32'h0020_0001);
        rd(5'h0C, d); chk("R9 pwd go ignored", d, IDLE_CTRL | 32'h0020_0000);
        chk("R9 req", {31'b0, mem_req}, 32'h0);
        wr(5'h0C, 32'h1);
        serve("R9 after wake", 32'h7000, 0);
        rd(5'h0C, d); chk("R9 done", d, IDLE_CTRL);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_ceil;
        t_go_busy;
        t_abort;
        t_limits;
        t_pwd;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule